// File: doc/BRIEF.md
# Video Lane Min/Max Execution Unit

This block is the execute stage for a packed-video minimum/maximum instruction. It receives a 64-bit instruction word and three 32-bit register operands, A, B and C. The first stage picks either the smaller or the larger of A and B. That comparison can be signed or unsigned. The second stage combines this value with C in one of eight ways:

- write it into one halfword or byte lane of C,
- add C to it,
- take a further minimum or maximum against C,
- or pass it through unchanged.

The unit is one register stage deep. When `in_valid` is high on a clock edge, the unit captures the instruction and operands on that edge. The result, the destination register index and the three source register indices appear on the outputs after that same edge. If the instruction word does not carry the unit's opcode, no output pulse is produced. Some encodings are recognised but not supported: saturation, condition-code generation, a non-register B operand, sub-word source formats, and unequal source signedness. For these the unit raises an unsupported flag next to the valid strobe, and the result value is undefined.

Top module: `vlane_minmax_unit`

## Requirements
- R1: An instruction is accepted only when bits 63:57 equal 7'b0011101. `out_valid` is high in the cycle after `in_valid` samples a matching word, and low otherwise.
- R2: Bit 56 selects the first stage function (1 = max(A,B), 0 = min(A,B)). Bit 48 set makes that comparison two's-complement signed; clear makes it unsigned.
- R3: The secondary operation code sits in bits 53:51. Code 0 writes the low 16 bits of the first-stage value into bits 31:16 of C and keeps C's bits 15:0.
- R4: Code 1 writes the first-stage value's low 16 bits into C bits 15:0. Code 2 writes its low 8 bits into C bits 7:0. Code 3 writes its low 8 bits into C bits 23:16. Every other bit of C is kept.
- R5: Code 4 outputs the first-stage value plus C, modulo 2^32.
- R6: Code 5 outputs the minimum of the first-stage value and C; code 6 outputs the maximum. This second comparison is signed when bit 54 is set and unsigned when it is clear.
- R7: Code 7 outputs the first-stage value unchanged.
- R8: `out_unsup` is high together with `out_valid` when any of these holds:
  - bit 50 is clear;
  - bits 38:37 are not 2'b11;
  - bits 30:29 are not 2'b11;
  - bit 48 differs from bit 49;
  - bit 55 is set;
  - bit 47 (condition-code request) is set.

  Otherwise `out_unsup` is low.
- R9: With each result, `out_dst_idx` carries bits 7:0 of the captured instruction. `out_idx_a` carries bits 15:8, `out_idx_b` carries bits 27:20 and `out_idx_c` carries bits 46:39.
- R10: A synchronous active-high reset clears `out_valid` and `out_unsup`.
- R11: `out_result` and the index outputs keep their last captured values in cycles where no matching instruction is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| in_instr | input | 64 | Instruction word |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_c | input | 32 | Operand C |
| out_valid | output | 1 | Result strobe, one cycle after capture |
| out_unsup | output | 1 | Captured encoding is unsupported |
| out_result | output | 32 | Result value |
| out_dst_idx | output | 8 | Destination register index |
| out_idx_a | output | 8 | Register index of A |
| out_idx_b | output | 8 | Register index of B |
| out_idx_c | output | 8 | Register index of C |

## Verification
The hardest case to reach is one where the signed and unsigned comparisons give different answers in the same instruction. This happens when one operand has its top bit set. For example, a first stage that is signed can feed a second stage that is unsigned, and only one of the two flag bits is wrong. To reach it, the stimulus uses operands of opposite sign (such as 0xFFFFFFF0 against 5) and crosses them with every combination of bits 48 and 54. A merge case whose first-stage value has non-zero upper bits is also used, so a wrong lane width or position shows in the untouched bits of C.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  localparam int INSTR_W = 64;
  localparam int IDX_W   = 8;

  localparam logic [6:0] OPC_PATTERN = 7'b0011101;
  localparam int OPC_HI      = 63;
  localparam int OPC_LO      = 57;
  localparam int BIT_FIRST_MAX = 56;
  localparam int BIT_SAT     = 55;
  localparam int BIT_DST_SGN = 54;
  localparam int SEC_HI      = 53;
  localparam int SEC_LO      = 51;
  localparam int BIT_B_REG   = 50;
  localparam int BIT_B_SGN   = 49;
  localparam int BIT_A_SGN   = 48;
  localparam int BIT_CC      = 47;
  localparam int FMT_A_LO    = 37;
  localparam int FMT_B_LO    = 29;
  localparam int IDX_C_LO    = 39;
  localparam int IDX_B_LO    = 20;
  localparam int IDX_A_LO    = 8;
  localparam int IDX_D_LO    = 0;

  localparam int LANE_COUNT  = 4;

  typedef enum logic [2:0] {
    SEC_INS_HI16 = 3'd0,
    SEC_INS_LO16 = 3'd1,
    SEC_INS_B0   = 3'd2,
    SEC_INS_B2   = 3'd3,
    SEC_ADD      = 3'd4,
    SEC_MIN      = 3'd5,
    SEC_MAX      = 3'd6,
    SEC_PASS     = 3'd7
  } sec_op_e;

  typedef struct packed {
    logic             hit;
    logic             unsup;
    logic             first_max;
    logic             first_signed;
    logic             second_signed;
    sec_op_e          sec;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] ia;
    logic [IDX_W-1:0] ib;
    logic [IDX_W-1:0] ic;
  } vdec_t;

  // Lane placement for the insert codes, indexed by operation code 0..3
  function automatic int lane_lsb(input int k);
    case (k)
      0: return 16;
      1: return 0;
      2: return 0;
      default: return 16;
    endcase
  endfunction

  function automatic int lane_width(input int k);
    return (k < 2) ? 16 : 8;
  endfunction
endpackage

// File: rtl/vlane_decode.sv
module vlane_decode
  import vlane_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output vdec_t              dec
);
  logic fmt_a_word;
  logic fmt_b_word;
  logic sign_mismatch;

  always_comb begin
    fmt_a_word    = (instr[FMT_A_LO +: 2] == 2'b11);
    fmt_b_word    = (instr[FMT_B_LO +: 2] == 2'b11);
    sign_mismatch = instr[BIT_A_SGN] ^ instr[BIT_B_SGN];

    dec.hit           = (instr[OPC_HI:OPC_LO] == OPC_PATTERN);
    dec.unsup         = !instr[BIT_B_REG] || !fmt_a_word || !fmt_b_word ||
                        sign_mismatch || instr[BIT_SAT] || instr[BIT_CC];
    dec.first_max     = instr[BIT_FIRST_MAX];
    dec.first_signed  = instr[BIT_A_SGN];
    dec.second_signed = instr[BIT_DST_SGN];
    dec.sec           = sec_op_e'(instr[SEC_HI:SEC_LO]);
    dec.dst           = instr[IDX_D_LO +: IDX_W];
    dec.ia            = instr[IDX_A_LO +: IDX_W];
    dec.ib            = instr[IDX_B_LO +: IDX_W];
    dec.ic            = instr[IDX_C_LO +: IDX_W];
  end
endmodule

// File: rtl/vlane_minmax.sv
module vlane_minmax #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              take_max,
  input  logic              is_signed,
  output logic [DATA_W-1:0] z
);
  logic x_less;

  always_comb begin
    if (is_signed) x_less = ($signed(x) < $signed(y));
    else           x_less = (x < y);
    if (take_max)  z = x_less ? y : x;
    else           z = x_less ? x : y;
  end
endmodule

// File: rtl/vlane_second.sv
module vlane_second
  import vlane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] v,
  input  logic [DATA_W-1:0] c,
  input  sec_op_e           sec,
  input  logic              is_signed,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] lane_out [LANE_COUNT];
  logic [DATA_W-1:0] mm_out;
  logic [DATA_W-1:0] sum_out;

  for (genvar k = 0; k < LANE_COUNT; k++) begin : g_lane
    localparam int LSB = lane_lsb(k);
    localparam int WID = lane_width(k);
    localparam logic [DATA_W-1:0] FIELD = {{(DATA_W-WID){1'b0}}, {WID{1'b1}}};
    localparam logic [DATA_W-1:0] MASK  = FIELD << LSB;
    assign lane_out[k] = (c & ~MASK) | ((v << LSB) & MASK);
  end

  vlane_minmax #(.DATA_W(DATA_W)) u_mm2 (
    .x         (v),
    .y         (c),
    .take_max  (sec == SEC_MAX),
    .is_signed (is_signed),
    .z         (mm_out)
  );

  assign sum_out = v + c;

  always_comb begin
    case (sec)
      SEC_INS_HI16: y = lane_out[0];
      SEC_INS_LO16: y = lane_out[1];
      SEC_INS_B0:   y = lane_out[2];
      SEC_INS_B2:   y = lane_out[3];
      SEC_ADD:      y = sum_out;
      SEC_MIN,
      SEC_MAX:      y = mm_out;
      default:      y = v;
    endcase
  end
endmodule

// File: rtl/vlane_minmax_unit.sv
module vlane_minmax_unit
  import vlane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic [DATA_W-1:0]   in_c,
  output logic                out_valid,
  output logic                out_unsup,
  output logic [DATA_W-1:0]   out_result,
  output logic [IDX_W-1:0]    out_dst_idx,
  output logic [IDX_W-1:0]    out_idx_a,
  output logic [IDX_W-1:0]    out_idx_b,
  output logic [IDX_W-1:0]    out_idx_c
);
  vdec_t             dec;
  logic [DATA_W-1:0] first_val;
  logic [DATA_W-1:0] second_val;
  logic              take;

  vlane_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  vlane_minmax #(.DATA_W(DATA_W)) u_mm1 (
    .x         (in_a),
    .y         (in_b),
    .take_max  (dec.first_max),
    .is_signed (dec.first_signed),
    .z         (first_val)
  );

  vlane_second #(.DATA_W(DATA_W)) u_sec (
    .v         (first_val),
    .c         (in_c),
    .sec       (dec.sec),
    .is_signed (dec.second_signed),
    .y         (second_val)
  );

  assign take = in_valid && dec.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_unsup <= 1'b0;
    end else begin
      out_valid <= take;
      out_unsup <= take && dec.unsup;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result  <= second_val;
      out_dst_idx <= dec.dst;
      out_idx_a   <= dec.ia;
      out_idx_b   <= dec.ib;
      out_idx_c   <= dec.ic;
    end
  end
endmodule

// File: rtl/vlane_minmax_chk.sv
module vlane_minmax_chk
  import vlane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [INSTR_W-1:0]  in_instr,
  input logic [DATA_W-1:0]   in_c,
  input logic                out_valid,
  input logic                out_unsup,
  input logic [DATA_W-1:0]   out_result,
  input logic [IDX_W-1:0]    out_dst_idx
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    live |-> (out_valid == $past(in_valid && (in_instr[63:57] == 7'b0011101))));

  assert_unsup_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_unsup |-> out_valid);

  assert_hi16_keeps_low_R3: assert property (@(posedge clk) disable iff (rst)
    (live && out_valid && !out_unsup && $past(in_instr[53:51]) == 3'd0)
      |-> out_result[15:0] == $past(in_c[15:0]));

  assert_lo16_keeps_high_R4: assert property (@(posedge clk) disable iff (rst)
    (live && out_valid && !out_unsup && $past(in_instr[53:51]) == 3'd1)
      |-> out_result[31:16] == $past(in_c[31:16]));

  assert_b2_keeps_rest_R4: assert property (@(posedge clk) disable iff (rst)
    (live && out_valid && !out_unsup && $past(in_instr[53:51]) == 3'd3)
      |-> (out_result[31:24] == $past(in_c[31:24]) &&
           out_result[15:0]  == $past(in_c[15:0])));

  assert_dst_index_R9: assert property (@(posedge clk) disable iff (rst)
    (live && out_valid) |-> out_dst_idx == $past(in_instr[7:0]));

  assert_result_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (live && !out_valid && $past(out_valid)) |-> $stable(out_result));
endmodule

bind vlane_minmax_unit vlane_minmax_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .in_c        (in_c),
  .out_valid   (out_valid),
  .out_unsup   (out_unsup),
  .out_result  (out_result),
  .out_dst_idx (out_dst_idx)
);

// File: tb/vlane_minmax_unit_tb_top.sv
module vlane_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_instr;
  logic [31:0] in_a, in_b, in_c;
  logic        out_valid, out_unsup;
  logic [31:0] out_result;
  logic [7:0]  out_dst_idx, out_idx_a, out_idx_b, out_idx_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vlane_minmax_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_unsup(out_unsup), .out_result(out_result),
    .out_dst_idx(out_dst_idx), .out_idx_a(out_idx_a), .out_idx_b(out_idx_b),
    .out_idx_c(out_idx_c)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Build a supported encoding
  function automatic logic [63:0] mk(input int op, input bit mx, input bit sa, input bit sd);
    logic [63:0] w = '0;
    w[63:57] = 7'b0011101;
    w[56]    = mx;
    w[54]    = sd;
    w[53:51] = op[2:0];
    w[50]    = 1'b1;
    w[49]    = sa;
    w[48]    = sa;
    w[38:37] = 2'b11;
    w[30:29] = 2'b11;
    w[7:0]   = 8'h2A;
    return w;
  endfunction

  function automatic logic [31:0] mm(input logic [31:0] x, input logic [31:0] y,
                                     input bit mx, input bit s);
    bit lt = s ? ($signed(x) < $signed(y)) : (x < y);
    return mx ? (lt ? y : x) : (lt ? x : y);
  endfunction

  function automatic logic [31:0] model(input int op, input bit mx, input bit sa, input bit sd,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    logic [31:0] v = mm(a, b, mx, sa);
    case (op)
      0: return {v[15:0], c[15:0]};
      1: return {c[31:16], v[15:0]};
      2: return {c[31:8], v[7:0]};
      3: return {c[31:24], v[7:0], c[15:0]};
      4: return v + c;
      5: return mm(v, c, 1'b0, sd);
      6: return mm(v, c, 1'b1, sd);
      default: return v;
    endcase
  endfunction

  task automatic issue(input logic [63:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0; in_instr = '0;
  endtask

  task automatic run_case(input string req, input int op, input bit mx, input bit sa,
                          input bit sd, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c);
    issue(mk(op, mx, sa, sd), a, b, c);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " unsup"}, 32'(out_unsup), 32'd0);
    chk({req, " result"}, out_result, model(op, mx, sa, sd, a, b, c));
  endtask

  task automatic t_reset_R10;
    rst = 1'b1; in_valid = 1'b1; in_instr = mk(7, 0, 0, 0) | (64'd1 << 55);
    in_a = '0; in_b = '0; in_c = '0;
    repeat (3) @(negedge clk);
    chk("R10 valid", 32'(out_valid), 32'd0);
    chk("R10 unsup", 32'(out_unsup), 32'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_match_R1_R11;
    logic [31:0] held;
    run_case("R1", 7, 1, 0, 0, 32'd9, 32'd4, 32'd0);
    held = out_result;
    issue(mk(7, 0, 0, 0) ^ (64'd1 << 60), 32'd1, 32'd2, 32'd3);
    chk("R1 no match", 32'(out_valid), 32'd0);
    chk("R11 held", out_result, held);
    @(negedge clk);
    chk("R1 idle", 32'(out_valid), 32'd0);
  endtask

  task automatic t_first_R2;
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        run_case("R2", 7, m[0], s[0], 0, 32'hFFFF_FFF0, 32'd5, 32'd0);
  endtask

  task automatic t_merge_R3_R4;
    run_case("R3", 0, 1, 0, 0, 32'h1234_ABCD, 32'h0000_0001, 32'h5566_7788);
    run_case("R4 lo16", 1, 1, 0, 0, 32'h1234_ABCD, 32'h0, 32'h5566_7788);
    run_case("R4 b0", 2, 1, 0, 0, 32'h1234_ABCD, 32'h0, 32'h5566_7788);
    run_case("R4 b2", 3, 1, 0, 0, 32'h1234_ABCD, 32'h0, 32'h5566_7788);
  endtask

  task automatic t_acc_R5;
    run_case("R5", 4, 1, 0, 0, 32'hFFFF_FFF0, 32'd1, 32'h0000_0020);
    run_case("R5", 4, 0, 1, 0, 32'd100, 32'hFFFF_FF00, 32'd7);
  endtask

  task automatic t_second_R6;
    for (int sa = 0; sa < 2; sa++)
      for (int sd = 0; sd < 2; sd++) begin
        run_case("R6 min", 5, 1, sa[0], sd[0], 32'd3, 32'hFFFF_FFF0, 32'h8000_0000);
        run_case("R6 max", 6, 0, sa[0], sd[0], 32'd3, 32'hFFFF_FFF0, 32'h8000_0000);
      end
  endtask

  task automatic t_pass_R7;
    run_case("R7", 7, 0, 1, 1, 32'h8000_0001, 32'h7FFF_FFFF, 32'hDEAD_BEEF);
  endtask

  task automatic t_unsup_R8;
    logic [63:0] base = mk(4, 0, 0, 0);
    logic [63:0] bad [6];
    bad[0] = base & ~(64'd1 << 50);
    bad[1] = base & ~(64'd1 << 37);
    bad[2] = base & ~(64'd1 << 30);
    bad[3] = base | (64'd1 << 49);
    bad[4] = base | (64'd1 << 55);
    bad[5] = base | (64'd1 << 47);
    for (int i = 0; i < 6; i++) begin
      issue(bad[i], 32'd1, 32'd2, 32'd3);
      chk("R8 valid", 32'(out_valid), 32'd1);
      chk("R8 flag", 32'(out_unsup), 32'd1);
    end
    issue(base, 32'd1, 32'd2, 32'd3);
    chk("R8 clean", 32'(out_unsup), 32'd0);
  endtask

  task automatic t_index_R9;
    logic [63:0] w = mk(7, 0, 0, 0);
    w[7:0] = 8'hC3; w[15:8] = 8'h11; w[27:20] = 8'h5E; w[46:39] = 8'hA7;
    issue(w, 32'd0, 32'd0, 32'd0);
    chk("R9 dst", 32'(out_dst_idx), 32'hC3);
    chk("R9 a", 32'(out_idx_a), 32'h11);
    chk("R9 b", 32'(out_idx_b), 32'h5E);
    chk("R9 c", 32'(out_idx_c), 32'hA7);
  endtask

  initial begin
    t_reset_R10();
    t_match_R1_R11();
    t_first_R2();
    t_merge_R3_R4();
    t_acc_R5();
    t_second_R6();
    t_pass_R7();
    t_unsup_R8();
    t_index_R9();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule